// File: doc/BRIEF.md
# CEC Transmit Status Tracker

This block follows the state of a consumer-electronics-control transmitter. It presents that state as two read-only status bytes and as a single interrupt line. A bit-level transmit engine, which lies outside this block, reports what happens on the bus through one-cycle event strobes: bus won, byte sent, message finished, and message failed. Software controls the block through a transmit-enable level and two write-one-to-clear pulses.

A message moves through two phases. While enabled and still waiting for the bus, the block reports that it is running but not yet transferring. After the bus is won, it reports that it is transferring. When the message ends, a sticky completion flag sets and, for a failed message, a fault flag sets beside it. Bytes are counted in a private accumulator. The visible count changes only when a message ends, so a reader never sees a partial total. A registered read port returns either status byte.

Top module: `cec_tx_status_tracker`

## Requirements
- R1: After a synchronous reset, running, transferring, done, error, irq, byte_count and rd_data are all 0.
- R2: running equals the value tx_en had on the previous clock edge.
- R3: transferring becomes 1 on ev_bus_won while tx_en is 1. It returns to 0 when the message ends or tx_en is 0. It is never 1 while running is 0.
- R4: A message end (ev_msg_done or ev_error while tx_en is 1) sets done on the next edge, and done then holds. irq always equals done.
- R5: ev_error sets done and error together on the same edge. A clean end without ev_error leaves error at 0. error is never 1 while done is 0.
- R6: A 1 on clr_done or on clr_error clears done and error on the next edge. tx_en at 0 also clears them.
- R7: When a clear pulse and a message end fall in the same cycle, the message end takes precedence: done (and error, for a fault) remain 1.
- R8: byte_count changes only on a message end. At that edge it takes the number of ev_byte_sent strobes in the message, counting a strobe that arrives in the ending cycle.
- R9: Either clear pulse sets byte_count to 0. tx_en at 0 leaves byte_count unchanged but discards the bytes counted so far for the unfinished message.
- R10: The byte total saturates at 255 and does not wrap.
- R11: A read with rd_en=1 updates rd_data on the next edge. Address 0 returns {4'b0000, error, done, transferring, running} with running at bit 0. Address 1 returns byte_count.
- R12: While tx_en is 0, the event strobes set no flag and count no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable level |
| clr_done | input | 1 | Write-one pulse that clears the completion flags and count |
| clr_error | input | 1 | Write-one pulse with the same clearing effect |
| ev_bus_won | input | 1 | Engine strobe: bus acquired, data now driven |
| ev_byte_sent | input | 1 | Engine strobe: one byte sent |
| ev_msg_done | input | 1 | Engine strobe: message finished cleanly |
| ev_error | input | 1 | Engine strobe: message ended with a fault |
| rd_en | input | 1 | Read request |
| rd_addr | input | 1 | 0 = flag byte, 1 = count byte |
| rd_data | output | 8 | Registered read data |
| running | output | 1 | Transmitter enabled |
| transferring | output | 1 | Data on the bus (valid while running) |
| done | output | 1 | Sticky message-end flag |
| error | output | 1 | Sticky fault flag, valid with done |
| byte_count | output | 8 | Bytes in the last finished message |
| irq | output | 1 | Interrupt, high while done is 1 |

## Verification
A message end and a software clear pulse can arrive in the same cycle. The same is true of the last byte strobe and the message end. The bench provokes both collisions on purpose. It raises clr_done together with ev_msg_done, and it raises ev_byte_sent together with both ev_msg_done and ev_error. It then judges the result at the ports: done and error must stay set, and the published total must include the final byte. It also reads both status bytes through the read port and compares them against queued expected values.

// File: rtl/cec_txs_pkg.sv
`timescale 1ns/1ps
package cec_txs_pkg;

  // Read-port word selection; the flag byte sits at address 0.
  typedef enum logic [0:0] {
    WORD_FLAGS = 1'b0,
    WORD_COUNT = 1'b1
  } word_sel_e;

  // Flag nibble, packed so that running lands on bit 0.
  typedef struct packed {
    logic fault;
    logic finished;
    logic on_bus;
    logic active;
  } flag_nib_t;

  localparam int FLAG_W = $bits(flag_nib_t);

endpackage

// File: rtl/cec_txs_phase.sv
`timescale 1ns/1ps
module cec_txs_phase (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic bus_won,
  input  logic complete,
  output logic active_o,
  output logic on_bus_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      on_bus_o <= 1'b0;
    end else begin
      active_o <= enable;
      if (!enable || complete) begin
        on_bus_o <= 1'b0;
      end else if (bus_won) begin
        on_bus_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cec_txs_flags.sv
`timescale 1ns/1ps
module cec_txs_flags (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic complete,
  input  logic fault,
  input  logic clear,
  output logic finished_o,
  output logic fault_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      finished_o <= 1'b0;
      fault_o    <= 1'b0;
    end else if (complete) begin
      finished_o <= 1'b1;
      fault_o    <= fault;
    end else if (clear || !enable) begin
      finished_o <= 1'b0;
      fault_o    <= 1'b0;
    end
  end

endmodule

// File: rtl/cec_txs_counter.sv
`timescale 1ns/1ps
module cec_txs_counter #(
  parameter int CNT_W    = 8,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             byte_stb,
  input  logic             complete,
  input  logic             clear,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_inc;

  generate
    if (SATURATE) begin : g_sat
      always_comb begin
        acc_inc = acc_q;
        if (byte_stb && (acc_q != CNT_MAX)) acc_inc = acc_q + 1'b1;
      end
    end else begin : g_wrap
      always_comb begin
        acc_inc = acc_q;
        if (byte_stb) acc_inc = acc_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      count_o <= '0;
    end else begin
      if (!enable || complete) acc_q <= '0;
      else                     acc_q <= acc_inc;

      if (complete)   count_o <= acc_inc;
      else if (clear) count_o <= '0;
    end
  end

endmodule

// File: rtl/cec_tx_status_tracker.sv
`timescale 1ns/1ps
module cec_tx_status_tracker
  import cec_txs_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DATA_W   = 8,
  parameter bit SATURATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              clr_done,
  input  logic              clr_error,
  input  logic              ev_bus_won,
  input  logic              ev_byte_sent,
  input  logic              ev_msg_done,
  input  logic              ev_error,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              running,
  output logic              transferring,
  output logic              done,
  output logic              error,
  output logic [CNT_W-1:0]  byte_count,
  output logic              irq
);

  // Engine strobes only count while the transmitter is enabled.
  logic stb_complete;
  logic stb_byte;
  logic stb_bus;
  logic sw_clear;

  assign stb_complete = tx_en & (ev_msg_done | ev_error);
  assign stb_byte     = tx_en & ev_byte_sent;
  assign stb_bus      = tx_en & ev_bus_won;
  assign sw_clear     = clr_done | clr_error;

  cec_txs_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .enable   (tx_en),
    .bus_won  (stb_bus),
    .complete (stb_complete),
    .active_o (running),
    .on_bus_o (transferring)
  );

  cec_txs_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .enable     (tx_en),
    .complete   (stb_complete),
    .fault      (ev_error),
    .clear      (sw_clear),
    .finished_o (done),
    .fault_o    (error)
  );

  cec_txs_counter #(
    .CNT_W    (CNT_W),
    .SATURATE (SATURATE)
  ) u_count (
    .clk      (clk),
    .rst      (rst),
    .enable   (tx_en),
    .byte_stb (stb_byte),
    .complete (stb_complete),
    .clear    (sw_clear),
    .count_o  (byte_count)
  );

  assign irq = done;

  // Read port: both words zero-extended to the data width.
  flag_nib_t        flags_now;
  logic [DATA_W-1:0] word_flags;
  logic [DATA_W-1:0] word_count;

  always_comb begin
    flags_now = '{fault: error, finished: done, on_bus: transferring, active: running};
    word_flags = '0;
    word_flags[FLAG_W-1:0] = flags_now;
    word_count = '0;
    word_count[CNT_W-1:0] = byte_count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (word_sel_e'(rd_addr))
        WORD_FLAGS: rd_data <= word_flags;
        default:    rd_data <= word_count;
      endcase
    end
  end

endmodule

// File: rtl/cec_txs_checker.sv
`timescale 1ns/1ps
module cec_txs_checker #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic              clr_done,
  input logic              clr_error,
  input logic              ev_msg_done,
  input logic              ev_error,
  input logic              rd_en,
  input logic              rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              running,
  input logic              transferring,
  input logic              done,
  input logic              error,
  input logic [CNT_W-1:0]  byte_count,
  input logic              irq
);

  logic ends_now;
  logic clear_now;
  assign ends_now  = tx_en && (ev_msg_done || ev_error);
  assign clear_now = clr_done || clr_error;

  assert_run_tracks_en_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (running == $past(tx_en)));

  assert_xfer_inside_run_R3: assert property (@(posedge clk) disable iff (rst)
    transferring |-> running);

  assert_end_sets_done_R4: assert property (@(posedge clk) disable iff (rst)
    ends_now |=> done);

  assert_irq_is_done_R4: assert property (@(posedge clk) disable iff (rst)
    irq == done);

  assert_fault_needs_done_R5: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

  assert_clear_drops_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (clear_now && !ends_now) |=> (!done && !error));

  assert_end_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clear_now && ends_now) |=> done);

  assert_count_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!ends_now && !clear_now) |=> $stable(byte_count));

  assert_flag_word_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_addr == 1'b0)) |=> (rd_data[DATA_W-1:4] == '0));

endmodule

bind cec_tx_status_tracker cec_txs_checker #(
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_en        (tx_en),
  .clr_done     (clr_done),
  .clr_error    (clr_error),
  .ev_msg_done  (ev_msg_done),
  .ev_error     (ev_error),
  .rd_en        (rd_en),
  .rd_addr      (rd_addr),
  .rd_data      (rd_data),
  .running      (running),
  .transferring (transferring),
  .done         (done),
  .error        (error),
  .byte_count   (byte_count),
  .irq          (irq)
);

// File: tb/tb_cec_tx_status_tracker.sv
`timescale 1ns/1ps
module tb_cec_tx_status_tracker;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       clr_done = 1'b0, clr_error = 1'b0;
  logic       ev_bus_won = 1'b0, ev_byte_sent = 1'b0, ev_msg_done = 1'b0, ev_error = 1'b0;
  logic       rd_en = 1'b0, rd_addr = 1'b0;
  logic [7:0] rd_data, byte_count;
  logic       running, transferring, done, error, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz

  cec_tx_status_tracker dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .clr_done(clr_done), .clr_error(clr_error),
    .ev_bus_won(ev_bus_won), .ev_byte_sent(ev_byte_sent), .ev_msg_done(ev_msg_done),
    .ev_error(ev_error), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .running(running), .transferring(transferring), .done(done), .error(error),
    .byte_count(byte_count), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One-cycle event burst.
  task automatic ev(input logic bw, input logic bs, input logic md,
                    input logic er, input logic cd, input logic ce);
    ev_bus_won = bw; ev_byte_sent = bs; ev_msg_done = md;
    ev_error = er; clr_done = cd; clr_error = ce;
    tick();
    ev_bus_won = 0; ev_byte_sent = 0; ev_msg_done = 0;
    ev_error = 0; clr_done = 0; clr_error = 0;
  endtask

  // Driver: issue a read and queue the expected word.
  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    sb_q.push_back('{exp: exp, tag: tag});
    rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
  endtask

  // Monitor: a read seen at an edge is compared just after that edge.
  always @(posedge clk) begin
    automatic bit fire = rd_en && !rst;
    #2;
    if (fire) begin
      if (sb_q.size() == 0) begin
        check("scoreboard underflow", 8'h00, 8'h01);
      end else begin
        automatic sb_item_t it = sb_q.pop_front();
        check(it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 running", {7'b0, running}, 8'h00);
    check("R1 done/irq", {6'b0, done, irq}, 8'h00);
    check("R1 count", byte_count, 8'h00);
    check("R1 rd_data", rd_data, 8'h00);
    rd(1'b0, 8'h00, "R1 flag word");

    // R12 events ignored while disabled
    ev(1, 1, 1, 1, 0, 0);
    check("R12 no flags", {4'b0, error, done, transferring, running}, 8'h00);
    rd(1'b1, 8'h00, "R12 count word");

    // R2 running follows enable
    tx_en = 1'b1; tick();
    check("R2 running", {7'b0, running}, 8'h01);
    rd(1'b0, 8'h01, "R11 flag word waiting");

    // R3 bus won
    ev(1, 0, 0, 0, 0, 0);
    check("R3 transferring", {7'b0, transferring}, 8'h01);
    rd(1'b0, 8'h03, "R11 flag word on bus");

    // R8 count hidden mid-message, last byte merges with end
    for (int i = 0; i < 3; i++) ev(0, 1, 0, 0, 0, 0);
    check("R8 count stable mid-message", byte_count, 8'h00);
    ev(0, 1, 1, 0, 0, 0);
    check("R8 published count", byte_count, 8'd4);
    check("R4 done+irq", {6'b0, done, irq}, 8'h03);
    check("R5 no fault on clean end", {7'b0, error}, 8'h00);
    check("R3 transferring drops at end", {7'b0, transferring}, 8'h00);
    rd(1'b0, 8'h05, "R11 flag word finished");
    rd(1'b1, 8'd4, "R11 count word");

    // R6 clear by clr_done
    ev(0, 0, 0, 0, 1, 0);
    check("R6 clr_done flags", {6'b0, done, error}, 8'h00);
    check("R9 clr_done count", byte_count, 8'h00);

    // R5 fault message, byte in ending cycle
    ev(1, 1, 0, 0, 0, 0);
    ev(0, 1, 0, 1, 0, 0);
    check("R5 fault+done", {6'b0, done, error}, 8'h03);
    check("R8 count with fault", byte_count, 8'd2);
    rd(1'b0, 8'h0D, "R11 flag word fault");

    // R5 clean end after fault without clear drops error
    ev(1, 0, 1, 0, 0, 0);
    check("R5 clean end resets fault", {6'b0, done, error}, 8'h02);
    check("R8 empty message count", byte_count, 8'd0);

    // R6 clear by clr_error
    ev(1, 1, 0, 1, 0, 0);
    ev(0, 0, 0, 0, 0, 1);
    check("R6 clr_error flags", {6'b0, done, error}, 8'h00);

    // R7 end and clear in same cycle
    ev(1, 1, 0, 0, 0, 0);
    ev(0, 0, 1, 0, 1, 0);
    check("R7 end beats clear", {6'b0, done, error}, 8'h02);
    check("R7 count kept", byte_count, 8'd1);
    ev(0, 0, 0, 1, 0, 1);
    check("R7 fault end beats clear", {6'b0, done, error}, 8'h03);

    // R6/R9 disable clears flags not count
    tx_en = 1'b0; tick();
    check("R6 disable clears flags", {6'b0, done, error}, 8'h00);
    check("R2 running off", {7'b0, running}, 8'h00);
    check("R9 disable keeps count", byte_count, 8'd0);

    // R9 disable discards partial message
    tx_en = 1'b1; tick();
    ev(1, 1, 1, 0, 0, 0);
    check("R9 setup count", byte_count, 8'd1);
    ev(0, 1, 0, 0, 0, 0);
    ev(0, 1, 0, 0, 0, 0);
    tx_en = 1'b0; tick();
    check("R9 count kept over disable", byte_count, 8'd1);
    ev(0, 1, 0, 0, 0, 0);
    tx_en = 1'b1; tick();
    ev(0, 1, 1, 0, 0, 0);
    check("R9 partial discarded", byte_count, 8'd1);
    ev(0, 0, 0, 0, 0, 1);
    check("R9 clr_error count", byte_count, 8'd0);

    // R10 saturation
    ev_byte_sent = 1'b1;
    repeat (300) tick();
    ev_byte_sent = 1'b0;
    ev(0, 0, 1, 0, 0, 0);
    check("R10 saturated count", byte_count, 8'd255);
    rd(1'b1, 8'd255, "R11 count word saturated");

    tick(); tick();
    check("scoreboard drained", 8'(sb_q.size()), 8'h00);
    finish_run();
  end

endmodule